// File: doc/BRIEF.md
# NAND Data Port Width Adapter

This block sits between a simple CPU register interface and the I/O bus of an 8-bit or 16-bit NAND device. A CPU access of 1, 2 or 4 bytes lands on one of three small register windows inside a chip select's space: a command window, an address window and a data window. Each access is turned into a sequence of device beats. Writes are split into little-endian byte or halfword beats. Reads assemble the returned beats back into a CPU word.

The window decides which strobe goes with each beat. Command beats raise the command-latch strobe. Address beats raise the address-latch strobe. Data beats raise neither.

Every beat is held on the device side until the device signals ready. The CPU sees a one-cycle acknowledge only after the last beat has been taken. When the chip select is not set up as NAND, or the offset misses all three windows, the access is acknowledged with no beats at all. Physical NAND timing and error correction belong to other blocks.

Top module: `nand_width_adapter`

## Requirements
- R1: Offsets 0x7C to 0x7F are the command window, and every beat of an access there has `nand_cle`=1 and `nand_ale`=0. Offsets 0x80 to 0x83 are the address window, where every beat has `nand_ale`=1 and `nand_cle`=0. Offsets 0x84 to 0x87 are the data window, where both strobes are 0. Any other offset produces no beats, an acknowledge, and read data of zero.
- R2: With `cs_wide`=0 (8-bit device), `cpu_size` 0, 1 and 2 (1, 2 and 4 bytes) give 1, 2 and 4 beats. Beat i carries `cpu_wdata[8i+7:8i]` on `nand_dout[7:0]`, so the least significant byte goes first. `cpu_size`=3 is treated as 4 bytes.
- R3: With `cs_wide`=1 (16-bit device), a 4-byte access gives two beats: beat 0 carries `cpu_wdata[15:0]` and beat 1 carries `cpu_wdata[31:16]`. A 2-byte access gives one beat carrying `cpu_wdata[15:0]`.
- R4: A 1-byte access to a 16-bit device gives one beat. A write drives `cpu_wdata[15:0]` unchanged. A read returns `nand_din[7:0]` of that beat.
- R5: Reads fill lanes in beat order.
  - On an 8-bit device, beat i's `nand_din[7:0]` lands in byte i and `nand_din[15:8]` is ignored.
  - On a 16-bit device, beat i's `nand_din` lands in halfword i.
  - `cpu_rdata` bits above the access size are zero.
  - On an 8-bit device, write beats drive `nand_dout[15:8]`=0.
- R6: The chip select counts as NAND only when `cs_type`=2. Types 0, 1 and 3 give no beats on any window, an acknowledge, and `cpu_rdata`=0.
- R7: Write accesses drive `nand_wr`=1 on every beat and return `cpu_rdata`=0. Read accesses drive `nand_wr`=0 and `nand_dout`=0.
- R8: While `nand_vld`=1 and `nand_rdy`=0, the beat's data, strobes and direction stay stable. The beat is taken at a clock edge where both are 1. `cpu_ack` is a single-cycle pulse in the cycle after the last beat is taken, or in the cycle after the request when there are no beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, accepted when the adapter is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_ofs | input | OFS_W | Offset of the access inside the chip-select window |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| cpu_wdata | input | 32 | Write data |
| cs_type | input | 2 | Device type of the chip select (2 = NAND) |
| cs_wide | input | 1 | Device width (1 = 16-bit, 0 = 8-bit) |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| nand_vld | output | 1 | A device beat is offered |
| nand_rdy | input | 1 | Device takes the offered beat |
| nand_wr | output | 1 | Beat direction (1 = write) |
| nand_cle | output | 1 | Command-latch strobe |
| nand_ale | output | 1 | Address-latch strobe |
| nand_dout | output | 16 | Beat write data |
| nand_din | input | 16 | Beat read data, sampled when the beat is taken |

## Verification
A wrong beat counter shows at the device port as a missing or extra beat, and at the CPU port as an acknowledge that comes early or late. A wrong lane index shows as a byte in the wrong position of `cpu_rdata`, or as the wrong value on `nand_dout`, from the second beat onward. A latched window kind or device width that is wrong shows on the strobes and the beat count from the first beat of the access. A stale read accumulator shows as nonzero high bytes on the next shorter read. The bench varies the device's stall length per beat, so a shift or capture that ignores the handshake shows up within a single access.

// File: rtl/nwa_pkg.sv
package nwa_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int BUS_W  = 16;

  typedef enum logic [1:0] {PK_NONE, PK_CMD, PK_ADDR, PK_DATA} port_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_DONE} seq_state_e;

  localparam logic [1:0] TYPE_NAND = 2'd2;

  function automatic logic [2:0] beats_for(logic wide, logic [1:0] sz);
    if (wide) return (sz >= 2'd2) ? 3'd2 : 3'd1;
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] size_mask(logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/nwa_decode.sv
module nwa_decode
  import nwa_pkg::*;
#(
  parameter int OFS_W   = 9,
  parameter int CMD_OFS = 'h7C,
  parameter int ADR_OFS = 'h80,
  parameter int DAT_OFS = 'h84
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [1:0]       dev_type,
  output port_kind_e       kind,
  output logic             active
);
  localparam logic [OFS_W-1:0] CMD_Q = OFS_W'(CMD_OFS >> 2);
  localparam logic [OFS_W-1:0] ADR_Q = OFS_W'(ADR_OFS >> 2);
  localparam logic [OFS_W-1:0] DAT_Q = OFS_W'(DAT_OFS >> 2);

  logic [OFS_W-1:0] word_idx;
  assign word_idx = ofs >> 2;

  always_comb begin
    if (word_idx == CMD_Q)      kind = PK_CMD;
    else if (word_idx == ADR_Q) kind = PK_ADDR;
    else if (word_idx == DAT_Q) kind = PK_DATA;
    else                        kind = PK_NONE;
  end

  assign active = (dev_type == TYPE_NAND) && (kind != PK_NONE);
endmodule

// File: rtl/nwa_seq.sv
module nwa_seq
  import nwa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       start_active,
  input  logic [2:0] beats,
  input  logic       rdy,
  output logic       idle,
  output logic       beat_vld,
  output logic       fire,
  output logic       done,
  output logic [1:0] beat_idx
);
  seq_state_e state;
  logic [2:0] beats_q;
  logic       last;

  assign last = ({1'b0, beat_idx} == (beats_q - 3'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      beat_idx <= '0;
      beats_q  <= 3'd1;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          beat_idx <= '0;
          beats_q  <= beats;
          state    <= start_active ? ST_BEAT : ST_DONE;
        end
        ST_BEAT: if (rdy) begin
          if (last) state <= ST_DONE;
          else      beat_idx <= beat_idx + 2'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle     = (state == ST_IDLE);
  assign beat_vld = (state == ST_BEAT);
  assign fire     = beat_vld && rdy;
  assign done     = (state == ST_DONE);
endmodule

// File: rtl/nwa_lanes.sv
module nwa_lanes
  import nwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wide,
  input  logic              fire,
  input  logic [1:0]        beat_idx,
  input  logic [BUS_W-1:0]  din,
  output logic [BUS_W-1:0]  dout,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] wr_sh;

  always_ff @(posedge clk) begin
    if (rst)       wr_sh <= '0;
    else if (load) wr_sh <= wdata;
    else if (fire) wr_sh <= wide ? (wr_sh >> 16) : (wr_sh >> 8);
  end

  assign dout = wide ? wr_sh[15:0] : {8'h00, wr_sh[7:0]};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HALF = g / 2;
    localparam int UPPER = g % 2;
    logic       hit;
    logic [7:0] src;
    assign hit = wide ? (beat_idx == 2'(HALF)) : (beat_idx == 2'(g));
    assign src = (wide && UPPER == 1) ? din[15:8] : din[7:0];
    always_ff @(posedge clk) begin
      if (rst || load)     rd_word[g*8 +: 8] <= 8'h00;
      else if (fire && hit) rd_word[g*8 +: 8] <= src;
    end
  end
endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
  import nwa_pkg::*;
#(
  parameter int OFS_W   = 9,
  parameter int CMD_OFS = 'h7C,
  parameter int ADR_OFS = 'h80,
  parameter int DAT_OFS = 'h84
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [OFS_W-1:0]  cpu_ofs,
  input  logic [1:0]        cpu_size,
  input  logic [31:0]       cpu_wdata,
  input  logic [1:0]        cs_type,
  input  logic              cs_wide,
  output logic              cpu_ack,
  output logic [31:0]       cpu_rdata,
  output logic              nand_vld,
  input  logic              nand_rdy,
  output logic              nand_wr,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [15:0]       nand_dout,
  input  logic [15:0]       nand_din
);
  port_kind_e kind_d, kind_q;
  logic       active_d;
  logic       idle, vld, fire, done, start;
  logic [1:0] beat_idx;
  logic       we_q, wide_q;
  logic [1:0] size_q;
  logic [BUS_W-1:0]  lane_dout;
  logic [WORD_W-1:0] rd_word;

  nwa_decode #(
    .OFS_W(OFS_W), .CMD_OFS(CMD_OFS), .ADR_OFS(ADR_OFS), .DAT_OFS(DAT_OFS)
  ) u_dec (
    .ofs(cpu_ofs), .dev_type(cs_type), .kind(kind_d), .active(active_d)
  );

  assign start = cpu_req && idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= PK_NONE;
      we_q   <= 1'b0;
      wide_q <= 1'b0;
      size_q <= 2'd0;
    end else if (start) begin
      kind_q <= kind_d;
      we_q   <= cpu_we;
      wide_q <= cs_wide;
      size_q <= cpu_size;
    end
  end

  nwa_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .start_active(active_d),
    .beats(beats_for(cs_wide, cpu_size)), .rdy(nand_rdy),
    .idle(idle), .beat_vld(vld), .fire(fire), .done(done), .beat_idx(beat_idx)
  );

  nwa_lanes u_lanes (
    .clk(clk), .rst(rst), .load(start), .wdata(cpu_wdata), .wide(wide_q),
    .fire(fire), .beat_idx(beat_idx), .din(nand_din),
    .dout(lane_dout), .rd_word(rd_word)
  );

  assign nand_vld  = vld;
  assign nand_wr   = vld && we_q;
  assign nand_cle  = vld && (kind_q == PK_CMD);
  assign nand_ale  = vld && (kind_q == PK_ADDR);
  assign nand_dout = (vld && we_q) ? lane_dout : '0;
  assign cpu_ack   = done;
  assign cpu_rdata = (done && !we_q) ? (rd_word & size_mask(size_q)) : '0;
endmodule

// File: rtl/nwa_checker.sv
module nwa_checker (
  input logic        clk,
  input logic        rst,
  input logic        nand_vld,
  input logic        nand_rdy,
  input logic        nand_wr,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic [15:0] nand_dout,
  input logic        cs_wide,
  input logic        cpu_ack
);
  logic [2:0] hs_cnt;

  always_ff @(posedge clk) begin
    if (rst || cpu_ack)          hs_cnt <= 3'd0;
    else if (nand_vld && nand_rdy) hs_cnt <= hs_cnt + 3'd1;
  end

  a_r1_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  a_r1_strobe_in_beat: assert property (@(posedge clk) disable iff (rst)
    (nand_cle || nand_ale) |-> nand_vld);

  a_r2_beat_limit: assert property (@(posedge clk) disable iff (rst)
    (nand_vld && nand_rdy) |-> (hs_cnt < 3'd4));

  a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (nand_vld && nand_wr && !cs_wide) |-> (nand_dout[15:8] == 8'h00));

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (nand_vld && !nand_rdy) |=> (nand_vld && $stable(nand_dout) &&
      $stable(nand_cle) && $stable(nand_ale) && $stable(nand_wr)));

  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);

  a_r8_ack_no_beat: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |-> !nand_vld);
endmodule

bind nand_width_adapter nwa_checker u_chk (
  .clk(clk), .rst(rst), .nand_vld(nand_vld), .nand_rdy(nand_rdy),
  .nand_wr(nand_wr), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_dout(nand_dout), .cs_wide(cs_wide), .cpu_ack(cpu_ack)
);

// File: tb/sim_nand_width_adapter.sv
module sim_nand_width_adapter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [8:0]  cpu_ofs = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic [1:0]  cs_type = '0;
  logic        cs_wide = 1'b0;
  logic        cpu_ack, nand_vld, nand_wr, nand_cle, nand_ale;
  logic [31:0] cpu_rdata;
  logic [15:0] nand_dout;
  logic        nand_rdy = 1'b0;
  logic [15:0] nand_din = '0;

  int checks = 0, failures = 0, cycles = 0, acc_num = 0;
  int nb = 0, wcnt = 0;
  logic [15:0] log_dout[8];
  logic        log_cle[8], log_ale[8], log_wr[8];
  logic [15:0] hold_dout;
  logic        hold_cle, hold_ale;

  always #10 clk = ~clk;

  nand_width_adapter u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ofs(cpu_ofs),
    .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cs_type(cs_type), .cs_wide(cs_wide),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .nand_vld(nand_vld), .nand_rdy(nand_rdy),
    .nand_wr(nand_wr), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_dout(nand_dout), .nand_din(nand_din)
  );

  task automatic chk(input string tag, input logic ok, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h (access %0d)", tag, act, exp, acc_num);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; failures++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      finish_run();
    end
  end

  // Device model: stalls a varying number of cycles per beat (R8)
  always @(negedge clk) begin
    if (rst || !nand_vld) begin
      nand_rdy = 1'b0; wcnt = 0;
    end else begin
      if (wcnt > 0)
        chk("R8 stable", nand_dout == hold_dout && nand_cle == hold_cle &&
            nand_ale == hold_ale, {nand_cle, nand_ale, 14'h0, nand_dout},
            {hold_cle, hold_ale, 14'h0, hold_dout});
      hold_dout = nand_dout; hold_cle = nand_cle; hold_ale = nand_ale;
      if (wcnt >= (nb + acc_num) % 3) begin
        nand_rdy = 1'b1;
        if (nb < 8) begin
          log_dout[nb] = nand_dout; log_cle[nb] = nand_cle;
          log_ale[nb] = nand_ale;   log_wr[nb]  = nand_wr;
        end
        nand_din = {8'(8'hB0 + nb), 8'(8'h30 + nb)};
        nb++;
        wcnt = 0;
      end else begin
        nand_rdy = 1'b0;
        wcnt++;
      end
    end
  end

  task automatic do_access(input logic [1:0] ty, input logic wd, input logic [8:0] ofs,
                           input logic [1:0] sz, input logic we, input logic [31:0] wdat);
    logic        act, inwin;
    int          exp_beats, nbytes, waited;
    logic [15:0] exp_d;
    logic [31:0] exp_r, got;
    string       tag;
    @(negedge clk);
    nb = 0;
    cs_type = ty; cs_wide = wd; cpu_ofs = ofs; cpu_size = sz;
    cpu_we = we; cpu_wdata = wdat; cpu_req = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0;
    waited = 0;
    while (!cpu_ack && waited < 100) begin @(negedge clk); waited++; end
    got = cpu_rdata;
    chk("R8 ack", cpu_ack, {31'h0, cpu_ack}, 32'h1);

    inwin = (ofs >= 9'h7C && ofs <= 9'h87);
    act = (ty == 2'd2) && inwin;
    nbytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    exp_beats = !act ? 0 : wd ? ((nbytes == 4) ? 2 : 1) : nbytes;
    tag = !inwin ? "R1 beats" : (ty != 2'd2) ? "R6 beats" : wd ? "R3 beats" : "R2 beats";
    chk(tag, nb == exp_beats, nb, exp_beats);

    for (int i = 0; i < exp_beats && i < nb; i++) begin
      exp_d = !we ? 16'h0 : wd ? wdat[16*i +: 16] : {8'h00, wdat[8*i +: 8]};
      tag = (wd && sz == 2'd0) ? "R4 dout" : wd ? "R3 dout" : "R2 dout";
      chk(tag, log_dout[i] == exp_d, {16'h0, log_dout[i]}, {16'h0, exp_d});
      chk("R1 strobes", log_cle[i] == (ofs < 9'h80) &&
          log_ale[i] == (ofs >= 9'h80 && ofs < 9'h84),
          {30'h0, log_cle[i], log_ale[i]},
          {30'h0, (ofs < 9'h80), (ofs >= 9'h80 && ofs < 9'h84)});
      chk("R7 dir", log_wr[i] == we, {31'h0, log_wr[i]}, {31'h0, we});
    end

    exp_r = '0;
    if (act && !we)
      for (int b = 0; b < nbytes; b++)
        exp_r[8*b +: 8] = wd ? ((b % 2 == 1) ? 8'(8'hB0 + b/2) : 8'(8'h30 + b/2))
                             : 8'(8'h30 + b);
    tag = we ? "R7 rdata" : !act ? "R6 rdata" : (wd && sz == 2'd0) ? "R4 rdata" : "R5 rdata";
    chk(tag, got == exp_r, got, exp_r);

    @(negedge clk);
    chk("R8 pulse", !cpu_ack, {31'h0, cpu_ack}, 32'h0);
    acc_num++;
  endtask

  initial begin
    logic [8:0] offs[9];
    offs = '{9'h78, 9'h7B, 9'h7C, 9'h7F, 9'h80, 9'h83, 9'h84, 9'h87, 9'h88};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset", !cpu_ack && !nand_vld && cpu_rdata == 0 && !nand_cle && !nand_ale,
        {cpu_ack, nand_vld, nand_cle, nand_ale, 28'h0} | cpu_rdata, 32'h0);
    for (int t = 0; t < 4; t++)
      for (int w = 0; w < 2; w++)
        for (int o = 0; o < 9; o++)
          for (int s = 0; s < 4; s++)
            for (int we = 0; we < 2; we++)
              do_access(2'(t), 1'(w), offs[o], 2'(s), 1'(we),
                        32'h1234_5678 ^ (32'(acc_num) * 32'h9E37_79B9));
    finish_run();
  end
endmodule